// File: doc/BRIEF.md
# Streaming LSB Steganography Embedder

This block hides one 128-bit payload word, typically a ciphertext block from an upstream cipher stage, in the low bit planes of a cover stream. Cover data arrives as beats of several bytes through a valid/ready handshake. Each beat has its low bit plane or planes overwritten with payload bits and leaves through a single output register, so the cover is never stored. Only the payload word is held.

A payload word is accepted on its own valid/ready handshake. A busy flag stays high until all 128 bits of the word have been written into the cover. The upstream encryptor's busy flag is an input. While that flag is high, no new word is taken, but embedding of the word already held continues. This lets the cipher work on the next block while the current one is being hidden. When no word is held, cover bytes pass through unchanged. A per-byte flag on the output marks the bytes that carry hidden bits.

Top module: `lsb_embed_top`

## Requirements
- R1: After reset, `out_valid_o` and `steg_busy_o` are 0, and `cov_ready_o` is 1. `pay_ready_o` is 1 whenever `enc_busy_i` is low.
- R2: `pay_ready_o` is high exactly when `steg_busy_o` and `enc_busy_i` are both low. A word is accepted on a clock edge where `pay_valid_i` and `pay_ready_o` are both high, and `steg_busy_o` is 1 from the next cycle.
- R3: With one plane in use, payload bits are consumed most significant first. Byte lane 0 (bits 7:0) takes the earliest bit, then lane 1, and so on. Each bit replaces bit 0 of its byte, and bits 7:1 pass through unchanged.
- R4: With two planes in use, each byte takes two consecutive payload bits. The earlier bit goes in bit 1 and the later bit in bit 0. Lane order is as in R3, and bits 7:2 pass through unchanged.
- R5: `steg_busy_o` falls on the edge of the beat that consumes bit 0 of the word. With 4-byte beats, that is the 32nd beat in one-plane mode and the 16th beat in two-plane mode. Later beats pass unmodified.
- R6: While `steg_busy_o` is 0, including the cycle in which a word is accepted, a cover beat leaves unchanged with `out_hid_o` = 0. Beats that carry payload bits have every bit of `out_hid_o` set.
- R7: A cover beat accepted on an edge appears on `out_data_o`, with `out_valid_o` = 1, right after that same edge. This gives one clock of latency.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, the output holds steady and `cov_ready_o` is 0. No payload bit is skipped or repeated across the stall.
- R9: The plane count is read from `planes_i` when a word is accepted. Code 2 selects two planes, and any other code selects one plane. Changes to `planes_i` while busy have no effect on the current word.
- R10: While `enc_busy_i` is 1, `pay_valid_i` is ignored. Embedding of the word already held continues normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| planes_i | input | 2 | Plane-count code (2 = two planes, else one) |
| enc_busy_i | input | 1 | Busy flag of the upstream encryptor |
| pay_valid_i | input | 1 | Payload word offered |
| pay_ready_o | output | 1 | Payload word can be accepted |
| pay_data_i | input | 128 | Payload word |
| cov_valid_i | input | 1 | Cover beat offered |
| cov_ready_o | output | 1 | Cover beat can be accepted |
| cov_data_i | input | 32 | Cover beat, byte lane 0 in bits 7:0 |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream accepts output beat |
| out_data_o | output | 32 | Output beat |
| out_hid_o | output | 4 | Per-lane flag: byte carries hidden bits |
| steg_busy_o | output | 1 | A payload word is being embedded |

## Verification
The bench targets the end of a word. A counter that is off by one beat either keeps overwriting cover after the last bit or releases busy one beat early, and that shows in the beat that follows. It stalls the output in the middle of a word. A design that advances the bit pointer on a stalled edge would shift later beats by one lane group. It changes the plane code while a word is in progress and presents a payload while the encryptor is busy. A design that samples the plane code live or ignores the encryptor flag would embed with the wrong layout or take the word early. It also checks the bit order inside a two-plane byte and the lane order, where a swapped index yields mirrored bits.

// File: rtl/lsb_embed_pkg.sv
package lsb_embed_pkg;

  typedef enum logic {
    PLANES_ONE = 1'b0,
    PLANES_TWO = 1'b1
  } plane_mode_e;

  localparam logic [1:0] PLANE_CODE_TWO = 2'd2;

  function automatic plane_mode_e decode_planes(input logic [1:0] code);
    return (code == PLANE_CODE_TWO) ? PLANES_TWO : PLANES_ONE;
  endfunction

endpackage

// File: rtl/lsb_payload_slot.sv
// Holds one payload word as a shift register and hands out the next
// bits, most significant first, in a window of 2*LANES bits.
module lsb_payload_slot
  import lsb_embed_pkg::*;
#(
  parameter int PAYLOAD_W = 128,
  parameter int LANES     = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_i,
  input  logic [PAYLOAD_W-1:0]   word_i,
  input  plane_mode_e            mode_i,
  input  logic                   take_i,
  output logic                   busy_o,
  output plane_mode_e            mode_o,
  output logic [2*LANES-1:0]     window_o
);
  localparam int CNT_W = $clog2(PAYLOAD_W + 1);
  localparam int WIN_W = 2 * LANES;

  logic [PAYLOAD_W-1:0] shreg;
  logic [CNT_W-1:0]     left;
  logic [CNT_W-1:0]     step;

  initial begin
    assert (PAYLOAD_W % WIN_W == 0)
      else $error("PAYLOAD_W must be a multiple of 2*LANES");
  end

  always_comb step = (mode_o == PLANES_TWO) ? CNT_W'(WIN_W) : CNT_W'(LANES);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      left   <= '0;
      busy_o <= 1'b0;
      mode_o <= PLANES_ONE;
    end else if (load_i) begin
      shreg  <= word_i;
      left   <= CNT_W'(PAYLOAD_W);
      busy_o <= 1'b1;
      mode_o <= mode_i;
    end else if (take_i && busy_o) begin
      shreg <= (mode_o == PLANES_TWO) ? (shreg << WIN_W) : (shreg << LANES);
      left  <= left - step;
      if (left == step) busy_o <= 1'b0;
    end
  end

  assign window_o = shreg[PAYLOAD_W-1 -: WIN_W];

  // R2: busy rises only after a word was loaded
  assert_busy_from_load_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(load_i));

  // R2: a word is never loaded on top of one still in use
  assert_no_overwrite_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !busy_o);

  // R5: idle slot has no bits left
  assert_idle_empty_R5: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> left == '0);

  // R9: plane mode stays fixed while busy
  assert_mode_fixed_R9: assert property (@(posedge clk) disable iff (rst)
    busy_o && $past(busy_o) |-> $stable(mode_o));

endmodule

// File: rtl/lsb_byte_merge.sv
// Overwrites the low plane(s) of each byte lane and registers the beat.
module lsb_byte_merge
  import lsb_embed_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [LANES*8-1:0]   in_data_i,
  input  logic                 embed_i,
  input  plane_mode_e          mode_i,
  input  logic [2*LANES-1:0]   window_i,
  output logic                 fire_o,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [LANES*8-1:0]   out_data_o,
  output logic [LANES-1:0]     out_hid_o
);
  localparam int WIN_W = 2 * LANES;

  logic [LANES*8-1:0] merged;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign fire_o     = in_valid_i && in_ready_o;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      merged[k*8 +: 8] = in_data_i[k*8 +: 8];
      if (embed_i) begin
        if (mode_i == PLANES_TWO) begin
          merged[k*8+1] = window_i[WIN_W-1-2*k];
          merged[k*8]   = window_i[WIN_W-2-2*k];
        end else begin
          merged[k*8]   = window_i[WIN_W-1-k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_hid_o   <= '0;
    end else if (fire_o) begin
      out_valid_o <= 1'b1;
      out_data_o  <= merged;
      out_hid_o   <= {LANES{embed_i}};
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  // R8: stalled output holds
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_hid_o));

  // R7: accepted beat is visible right after its edge
  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(fire_o) |-> out_valid_o);

  // R6: beat without payload leaves unchanged and unflagged
  assert_passthru_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(fire_o) && !$past(embed_i) |->
      out_data_o == $past(in_data_i) && out_hid_o == '0);

endmodule

// File: rtl/lsb_embed_top.sv
module lsb_embed_top
  import lsb_embed_pkg::*;
#(
  parameter int PAYLOAD_W = 128,
  parameter int LANES     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           planes_i,
  input  logic                 enc_busy_i,
  input  logic                 pay_valid_i,
  output logic                 pay_ready_o,
  input  logic [PAYLOAD_W-1:0] pay_data_i,
  input  logic                 cov_valid_i,
  output logic                 cov_ready_o,
  input  logic [LANES*8-1:0]   cov_data_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [LANES*8-1:0]   out_data_o,
  output logic [LANES-1:0]     out_hid_o,
  output logic                 steg_busy_o
);
  logic               load;
  logic               fire;
  plane_mode_e        mode_q;
  logic [2*LANES-1:0] window;

  assign pay_ready_o = !steg_busy_o && !enc_busy_i;
  assign load        = pay_valid_i && pay_ready_o;

  lsb_payload_slot #(.PAYLOAD_W(PAYLOAD_W), .LANES(LANES)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .word_i   (pay_data_i),
    .mode_i   (decode_planes(planes_i)),
    .take_i   (fire),
    .busy_o   (steg_busy_o),
    .mode_o   (mode_q),
    .window_o (window)
  );

  lsb_byte_merge #(.LANES(LANES)) u_merge (
    .clk         (clk),
    .rst         (rst),
    .in_valid_i  (cov_valid_i),
    .in_ready_o  (cov_ready_o),
    .in_data_i   (cov_data_i),
    .embed_i     (steg_busy_o),
    .mode_i      (mode_q),
    .window_i    (window),
    .fire_o      (fire),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_hid_o   (out_hid_o)
  );

  // R10: no word is taken while the encryptor is busy
  assert_enc_block_R10: assert property (@(posedge clk) disable iff (rst)
    enc_busy_i && !steg_busy_o |=> !steg_busy_o);

  // R2: an accepted word makes the block busy next cycle
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    pay_valid_i && pay_ready_o |=> steg_busy_o);

endmodule

// File: tb/lsb_embed_top_test.sv
`timescale 1ns/1ps
module lsb_embed_top_test;
  localparam int PW = 128;
  localparam int LN = 4;
  localparam int DW = LN * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    planes_i = 2'd1;
  logic          enc_busy_i = 1'b0;
  logic          pay_valid_i = 1'b0;
  logic          pay_ready_o;
  logic [PW-1:0] pay_data_i = '0;
  logic          cov_valid_i = 1'b0;
  logic          cov_ready_o;
  logic [DW-1:0] cov_data_i = '0;
  logic          out_valid_o;
  logic          out_ready_i = 1'b1;
  logic [DW-1:0] out_data_o;
  logic [LN-1:0] out_hid_o;
  logic          steg_busy_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [PW-1:0] cur_word;
  bit            cur_two;
  bit            cur_active = 1'b0;
  int            used = 0;

  always #2.5 clk = ~clk;

  lsb_embed_top uut (
    .clk(clk), .rst(rst), .planes_i(planes_i), .enc_busy_i(enc_busy_i),
    .pay_valid_i(pay_valid_i), .pay_ready_o(pay_ready_o), .pay_data_i(pay_data_i),
    .cov_valid_i(cov_valid_i), .cov_ready_o(cov_ready_o), .cov_data_i(cov_data_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
    .out_hid_o(out_hid_o), .steg_busy_o(steg_busy_o)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(input logic [DW-1:0] d);
    logic [DW-1:0] r = d;
    if (cur_active) begin
      for (int k = 0; k < LN; k++) begin
        if (cur_two) begin
          r[k*8+1] = cur_word[PW-1-(used+2*k)];
          r[k*8]   = cur_word[PW-1-(used+2*k+1)];
        end else begin
          r[k*8]   = cur_word[PW-1-(used+k)];
        end
      end
    end
    return r;
  endfunction

  function automatic void advance();
    if (cur_active) begin
      used += cur_two ? 2*LN : LN;
      if (used >= PW) cur_active = 1'b0;
    end
  endfunction

  function automatic logic [DW-1:0] cov_pat(input int i);
    return 32'hA5C3_0F96 ^ (32'h9E37_79B9 * (i + 1));
  endfunction

  task automatic beat(input string req, input logic [DW-1:0] d);
    logic [DW-1:0] e;
    logic [LN-1:0] eh;
    e  = model(d);
    eh = cur_active ? '1 : '0;
    @(negedge clk);
    cov_valid_i = 1'b1;
    cov_data_i  = d;
    @(negedge clk);
    cov_valid_i = 1'b0;
    check(req, "out_valid", 64'(out_valid_o), 64'd1);
    check(req, "out_data",  64'(out_data_o),  64'(e));
    check(req, "out_hid",   64'(out_hid_o),   64'(eh));
    advance();
  endtask

  task automatic load(input logic [PW-1:0] w, input logic [1:0] code);
    @(negedge clk);
    check("R2", "pay_ready before load", 64'(pay_ready_o), 64'd1);
    pay_valid_i = 1'b1;
    pay_data_i  = w;
    planes_i    = code;
    @(negedge clk);
    pay_valid_i = 1'b0;
    check("R2", "busy after load", 64'(steg_busy_o), 64'd1);
    cur_word = w;
    cur_two  = (code == 2'd2);
    cur_active = 1'b1;
    used = 0;
  endtask

  task automatic t_reset();
    check("R1", "out_valid", 64'(out_valid_o), 64'd0);
    check("R1", "busy",      64'(steg_busy_o), 64'd0);
    check("R1", "cov_ready", 64'(cov_ready_o), 64'd1);
    check("R1", "pay_ready", 64'(pay_ready_o), 64'd1);
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R7", "no output before beat", 64'(out_valid_o), 64'd0);
    beat("R6", 32'hDEAD_BEEF);
    beat("R7", 32'h0123_4567);
    @(negedge clk);
    check("R7", "valid drops after beat", 64'(out_valid_o), 64'd0);
  endtask

  task automatic t_one_plane();
    load(128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F, 2'd1);
    for (int i = 0; i < 31; i++) beat("R3", cov_pat(i));
    check("R5", "busy before last beat", 64'(steg_busy_o), 64'd1);
    beat("R3", cov_pat(31));
    check("R5", "busy after 32 beats", 64'(steg_busy_o), 64'd0);
    beat("R5", 32'h5555_AAAA);
  endtask

  task automatic t_two_plane();
    load(128'h8C3A_51F0_0E9B_D726_4A1F_C083_B56E_2D97, 2'd2);
    @(negedge clk) planes_i = 2'd1;
    for (int i = 0; i < 15; i++) beat("R4", cov_pat(40 + i));
    check("R9", "busy before beat 16", 64'(steg_busy_o), 64'd1);
    beat("R9", cov_pat(55));
    check("R5", "busy after 16 beats", 64'(steg_busy_o), 64'd0);
    beat("R5", 32'hFFFF_0000);
  endtask

  task automatic t_code3();
    load(128'h1357_9BDF_2468_ACE0_FEDC_BA98_7654_3210, 2'd3);
    for (int i = 0; i < 32; i++) beat("R9", cov_pat(70 + i));
    check("R9", "code 3 ends after 32 beats", 64'(steg_busy_o), 64'd0);
  endtask

  task automatic t_enc_busy();
    @(negedge clk);
    enc_busy_i  = 1'b1;
    pay_valid_i = 1'b1;
    pay_data_i  = '1;
    @(negedge clk);
    check("R10", "pay_ready while enc busy", 64'(pay_ready_o), 64'd0);
    @(negedge clk);
    pay_valid_i = 1'b0;
    check("R10", "no load while enc busy", 64'(steg_busy_o), 64'd0);
    beat("R10", 32'hC0FF_EE00);
    enc_busy_i = 1'b0;
    load(128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0, 2'd2);
    enc_busy_i = 1'b1;
    for (int i = 0; i < 16; i++) beat("R10", cov_pat(110 + i));
    check("R10", "word finished under enc busy", 64'(steg_busy_o), 64'd0);
    check("R2", "pay_ready low, enc busy", 64'(pay_ready_o), 64'd0);
    @(negedge clk) enc_busy_i = 1'b0;
    #1 check("R2", "pay_ready high, both idle", 64'(pay_ready_o), 64'd1);
  endtask

  task automatic t_stall();
    logic [DW-1:0] e0, e1, d0, d1;
    load(128'h9A8B_7C6D_5E4F_3021_1203_F4E5_D6C7_B8A9, 2'd1);
    d0 = cov_pat(200);
    d1 = cov_pat(201);
    e0 = model(d0);
    @(negedge clk);
    out_ready_i = 1'b0;
    cov_valid_i = 1'b1;
    cov_data_i  = d0;
    @(negedge clk);
    advance();
    e1 = model(d1);
    cov_data_i = d1;
    check("R8", "first beat out", 64'(out_data_o), 64'(e0));
    check("R8", "cov_ready low in stall", 64'(cov_ready_o), 64'd0);
    repeat (3) @(negedge clk);
    check("R8", "valid held", 64'(out_valid_o), 64'd1);
    check("R8", "data held", 64'(out_data_o), 64'(e0));
    out_ready_i = 1'b1;
    @(negedge clk);
    cov_valid_i = 1'b0;
    check("R8", "beat after stall", 64'(out_data_o), 64'(e1));
    check("R8", "hid after stall", 64'(out_hid_o), 64'hF);
    advance();
    for (int i = 0; i < 30; i++) beat("R8", cov_pat(202 + i));
    check("R8", "no bit lost, busy clear", 64'(steg_busy_o), 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle();
    t_one_plane();
    t_two_plane();
    t_code3();
    t_enc_busy();
    t_stall();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule